// File: doc/BRIEF.md
# Half-Bridge Adaptive Dead-Time Driver

This block turns a digital phase clock into two gate enables, one for the upper switch and one for the lower switch of a half-bridge. The phase clock pulses once per sawtooth wrap, which happens twice per bridge period. The two switches conduct on alternate phases. Between any two conduction intervals both enables are held low for a dead time. The dead time ends early once a slope-detect input reports that the bridge midpoint has finished its swing. It never drops below a fixed minimum and never exceeds a quarter of the measured bridge period.

The block measures the spacing of phase pulses in clock cycles. It doubles that spacing to get the bridge period and shifts it right by two to get the upper limit on dead time. Before the first spacing has been measured, a parameter supplies that limit. The slope input is asynchronous. It passes through a two-flop synchronizer and then a run-length filter, so a pulse shorter than the filter length never reaches the controller.

After enable, the lower switch turns on first. It stays on for an extended time so that the bootstrap supply can charge. The state machine has six states:
- ST_IDLE: both off.
- ST_BOOT: long lower pulse.
- ST_DEAD_LH: gap before the upper switch.
- ST_HI: upper on.
- ST_DEAD_HL: gap before the lower switch.
- ST_LO: lower on.

Its transitions are:
- ST_IDLE goes to ST_BOOT when `en` is high.
- ST_BOOT goes to ST_DEAD_LH when the boot count expires.
- ST_DEAD_LH goes to ST_HI when the dead time is done.
- ST_HI goes to ST_DEAD_HL on a phase pulse.
- ST_DEAD_HL goes to ST_LO when the dead time is done.
- ST_LO goes to ST_DEAD_LH on a phase pulse.
- Every state returns to ST_IDLE when `en` is low.

Top module: `hb_deadtime_drv`

## Requirements
- R1: While `rst_n` is low, or in any cycle in which `en` is low, `gate_hi` and `gate_lo` are both 0 in that same cycle.
- R2: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R3: In the first cycle after `en` is sampled high out of ST_IDLE, `gate_lo` is 1 and `gate_hi` is 0; no upper pulse precedes the first lower pulse.
- R4: The first lower pulse after enable lasts exactly BOOT_CYC cycles (default 40, i.e. two half-periods of 20 cycles), and phase pulses during it are ignored.
- R5: In steady running with phase pulses every N cycles, a conduction interval ends in the cycle after a phase pulse is sampled. Upper and lower pulses each last N minus the dead time.
- R6: The dead time is exactly MIN_DEAD cycles (default 3) when the filtered slope input is already 1 at the start of the gap.
- R7: With the slope input held at 0, the dead time equals (2*N)>>2 cycles, where N is the last measured spacing of phase pulses; with N=20 that is 10 cycles.
- R8: When (2*N)>>2 is below MIN_DEAD, the upper limit is raised to MIN_DEAD, so the gap is MIN_DEAD cycles.
- R9: If `slope_raw` goes to 1 before the clock edge that ends dead cycle j and stays at 1, the gap ends after dead cycle j+2+FILT_CYC, within the min/max bounds. With defaults and j=1, the gap is 5 cycles.
- R10: A 1 pulse on `slope_raw` lasting fewer than FILT_CYC clock cycles (default 2) has no effect on the dead time.
- R11: Lowering `en` and raising it again restarts the sequence with a new BOOT_CYC lower pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces both gates off |
| phase_tick | input | 1 | One-cycle pulse at each sawtooth wrap (twice per bridge period) |
| slope_raw | input | 1 | Asynchronous slope detect, 1 = midpoint swing finished |
| gate_hi | output | 1 | Upper switch enable |
| gate_lo | output | 1 | Lower switch enable |

## Verification
The gap assertions assume three things about the inputs:
- `phase_tick` is a single-cycle pulse whose spacing leaves room for at least one conduction cycle after the longest gap.
- `en` changes at most once per few cycles.
- The period measurement only uses spacings that fit the counter.

The stimulus keeps the spacing between 4 and 40 cycles. It changes the spacing only between whole bridge periods and waits several periods before each comparison. The filter assertions assume nothing of `slope_raw` beyond it being a plain level. The stimulus drives it only at falling clock edges, in pulses of one cycle or as held levels.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BOOT    = 3'd1,
        ST_DEAD_LH = 3'd2,
        ST_HI      = 3'd3,
        ST_DEAD_HL = 3'd4,
        ST_LO      = 3'd5
    } hb_state_e;

endpackage

// File: rtl/hbdt_slope_filt.sv
module hbdt_slope_filt #(
    parameter int FILT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
            filt_q <= 1'b0;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], raw_in};
            if (sync_q[1] == filt_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_CYC - 1)) begin
                filt_q <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign clean_out = filt_q;

    // R10
    filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_q) |-> $past(sync_q[1]));

    // R10
    filt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_q) |-> !$past(sync_q[1]));

endmodule

// File: rtl/hbdt_period_meas.sv
module hbdt_period_meas #(
    parameter int PW       = 12,
    parameter int MIN_DEAD = 3,
    parameter int DEF_MAX  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_tick,
    output logic [PW-1:0] max_dead
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] max_q;
    logic          seen_q;
    logic [PW:0]   period_w;
    logic [PW:0]   quarter_w;

    // bridge period = two phase spacings, limit = a quarter of it
    assign period_w  = {cnt_q, 1'b0};
    assign quarter_w = period_w >> 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            max_q  <= PW'(DEF_MAX);
            seen_q <= 1'b0;
        end else if (phase_tick) begin
            cnt_q  <= PW'(1);
            seen_q <= 1'b1;
            if (seen_q) begin
                max_q <= quarter_w[PW-1:0];
            end
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign max_dead = (max_q < PW'(MIN_DEAD)) ? PW'(MIN_DEAD) : max_q;

endmodule

// File: rtl/hb_deadtime_drv.sv
module hb_deadtime_drv
    import hbdt_pkg::*;
#(
    parameter int PW       = 12,
    parameter int MIN_DEAD = 3,
    parameter int DEF_MAX  = 8,
    parameter int FILT_CYC = 2,
    parameter int NOM_HALF = 20,
    parameter int BOOT_CYC = 2 * NOM_HALF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic phase_tick,
    input  logic slope_raw,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int BW = $clog2(BOOT_CYC + 1);

    hb_state_e     state_q, state_d;
    logic [PW-1:0] dcnt_q;
    logic [PW-1:0] lat_max_q;
    logic [BW-1:0] bcnt_q;
    logic [PW-1:0] max_dead;
    logic          slope_ok;
    logic          dead_done;
    logic          in_dead_d;
    logic          in_dead_q;

    hbdt_slope_filt #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (slope_raw),
        .clean_out (slope_ok)
    );

    hbdt_period_meas #(.PW(PW), .MIN_DEAD(MIN_DEAD), .DEF_MAX(DEF_MAX)) u_meas (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_tick (phase_tick),
        .max_dead   (max_dead)
    );

    assign dead_done = ((dcnt_q >= PW'(MIN_DEAD)) && slope_ok) || (dcnt_q >= lat_max_q);
    assign in_dead_d = (state_d == ST_DEAD_LH) || (state_d == ST_DEAD_HL);
    assign in_dead_q = (state_q == ST_DEAD_LH) || (state_q == ST_DEAD_HL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_BOOT;
                ST_BOOT:    if (bcnt_q == '0) state_d = ST_DEAD_LH;
                ST_DEAD_LH: if (dead_done) state_d = ST_HI;
                ST_HI:      if (phase_tick) state_d = ST_DEAD_HL;
                ST_DEAD_HL: if (dead_done) state_d = ST_LO;
                ST_LO:      if (phase_tick) state_d = ST_DEAD_LH;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // gap and boot counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt_q    <= '0;
            lat_max_q <= PW'(MIN_DEAD);
            bcnt_q    <= '0;
        end else begin
            if (in_dead_d && (state_d != state_q)) begin
                dcnt_q    <= PW'(1);
                lat_max_q <= max_dead;
            end else if (in_dead_q) begin
                dcnt_q <= dcnt_q + 1'b1;
            end
            if ((state_d == ST_BOOT) && (state_q != ST_BOOT)) begin
                bcnt_q <= BW'(BOOT_CYC - 1);
            end else if ((state_q == ST_BOOT) && (bcnt_q != '0)) begin
                bcnt_q <= bcnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        if (en) begin
            unique case (state_q)
                ST_HI:          gate_hi = 1'b1;
                ST_LO, ST_BOOT: gate_lo = 1'b1;
                default: begin
                    gate_hi = 1'b0;
                    gate_lo = 1'b0;
                end
            endcase
        end
    end

    // checker state: run of cycles with both gates off
    logic [PW-1:0] off_run_q;
    logic          armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run_q <= '0;
            armed_q   <= 1'b0;
        end else begin
            armed_q <= en && (armed_q || gate_hi || gate_lo);
            if (gate_hi || gate_lo) begin
                off_run_q <= '0;
            end else if (off_run_q != '1) begin
                off_run_q <= off_run_q + 1'b1;
            end
        end
    end

    // R6
    gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($rose(gate_hi) || $rose(gate_lo))) |-> (off_run_q >= PW'(MIN_DEAD)));

    // R7 R8
    gap_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($rose(gate_hi) || $rose(gate_lo))) |-> (off_run_q <= lat_max_q));

    // R3
    boot_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en) ##1 en) |-> (gate_lo && !gate_hi));

endmodule

// File: tb/hb_deadtime_drv_tb_top.sv
`timescale 1ns/1ps
module hb_deadtime_drv_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic phase_tick = 1'b0;
    logic slope_raw = 1'b0;
    logic gate_hi, gate_lo;
    int   half = 20;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hb_deadtime_drv dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .phase_tick (phase_tick),
        .slope_raw  (slope_raw),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo)
    );

    // phase pulse generator, one pulse every `half` cycles
    initial begin
        forever begin
            @(negedge clk) phase_tick = 1'b1;
            @(negedge clk) phase_tick = 1'b0;
            repeat (half - 2) @(negedge clk);
        end
    end

    // monitor of pulse and gap lengths
    int gap_run = 0, last_gap_hi = 0, last_gap_lo = 0;
    int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    int hi_falls = 0, lo_falls = 0, hi_rises = 0, overlap = 0;

    always @(negedge clk) begin
        if (gate_hi && gate_lo) overlap++;
        if (!gate_hi && !gate_lo) begin
            gap_run++;
        end else if (gap_run != 0) begin
            if (gate_hi) begin
                last_gap_hi = gap_run;
                hi_rises++;
            end else begin
                last_gap_lo = gap_run;
            end
            gap_run = 0;
        end
        if (gate_hi) hi_run++;
        else if (hi_run != 0) begin
            last_hi = hi_run; hi_run = 0; hi_falls++;
        end
        if (gate_lo) lo_run++;
        else if (lo_run != 0) begin
            last_lo = lo_run; lo_run = 0; lo_falls++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    localparam int NV = 6;
    localparam int VH [NV] = '{20, 20, 12, 30, 4, 40};
    localparam int VS [NV] = '{0, 1, 0, 0, 0, 1};
    localparam int VG [NV] = '{10, 3, 6, 15, 3, 3};

    initial begin
        int t;
        // R1: reset dominates even with en high
        en = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 reset gates", {30'd0, gate_hi, gate_lo}, 0);
        en = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        repeat (50) @(negedge clk);

        // R3, R4: first enable
        en = 1'b1;
        @(negedge clk);
        check("R3 lo first", {30'd0, gate_hi, gate_lo}, 1);
        wait (lo_falls >= 1);
        check("R3 no hi before boot", hi_rises, 0);
        check("R4 boot length", last_lo, 40);
        wait (hi_rises >= 1);
        check("R7 first gap", last_gap_hi, 10);

        // R5 R6 R7 R8: vector table
        for (int i = 0; i < NV; i++) begin
            half = VH[i];
            slope_raw = VS[i][0];
            t = hi_falls;
            wait (hi_falls >= t + 4);
            check("R6/R7/R8 gap", last_gap_hi, VG[i]);
            check("R5 hi len", last_hi, VH[i] - VG[i]);
            check("R5 lo len", last_lo, VH[i] - VG[i]);
        end

        // R9: slope rises in dead cycle 1
        half = 20;
        slope_raw = 1'b0;
        t = hi_falls;
        wait (hi_falls >= t + 4);
        t = lo_falls;
        wait (lo_falls > t);
        slope_raw = 1'b1;
        t = hi_rises;
        wait (hi_rises > t);
        check("R9 adaptive gap", last_gap_hi, 5);
        slope_raw = 1'b0;
        t = hi_falls;
        wait (hi_falls >= t + 2);

        // R10: one-cycle glitch ignored
        t = lo_falls;
        wait (lo_falls > t);
        slope_raw = 1'b1;
        @(negedge clk) slope_raw = 1'b0;
        t = hi_rises;
        wait (hi_rises > t);
        check("R10 glitch gap", last_gap_hi, 10);

        // R1: disable
        @(negedge clk) en = 1'b0;
        #1 check("R1 disable same cycle", {30'd0, gate_hi, gate_lo}, 0);
        repeat (5) @(negedge clk);
        check("R1 disable held", {30'd0, gate_hi, gate_lo}, 0);

        // R11: re-enable restarts boot
        en = 1'b1;
        t = lo_falls;
        @(negedge clk);
        check("R11 lo first again", {30'd0, gate_hi, gate_lo}, 1);
        wait (lo_falls > t);
        check("R11 boot length again", last_lo, 40);
        repeat (40) @(negedge clk);

        check("R2 no overlap", overlap, 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule